// File: doc/BRIEF.md
# Register-Pair Word Arithmetic Unit

This combinational unit performs sixteen-bit arithmetic on an accumulator pair made of two byte registers, a low register and a high register, against a sixteen-bit word that has already been fetched and assembled from memory. One operation select chooses between adding the word to the pair, subtracting it from the pair, comparing the pair with it, stepping the word up or down by one, or loading the word into the pair.

Outputs are the two result bytes, five condition flags (negative, overflow, half-carry, zero, carry), a write-enable for each flag, and two destination strobes that say whether the result goes back into the pair or back into the memory word. The surrounding core handles the fetch of both bytes, the address formation and the instruction decode. It commits the result and the enabled flags in the cycle it samples them.

Top module: `ya_word_alu`

## Requirements
- R1: Operation code 0 (add) gives pair + word modulo 2^16 with no carry-in, asserts pair_we_o, deasserts mem_we_o and enables all five flags.
- R2: Operation code 1 (subtract) gives pair + (~word + 1) modulo 2^16 with no borrow-in, asserts pair_we_o, deasserts mem_we_o and enables all five flags.
- R3: For add and subtract, H is the carry into bit 12 of the sum, where the second operand is the word for add and its ones' complement (with carry-in 1) for subtract.
- R4: For add and subtract, V is set on two's-complement sixteen-bit overflow and C is the carry out of bit 15. For subtract, C is 1 exactly when pair >= word (unsigned).
- R5: Operation code 2 (compare) gives pair - word on the result pins, enables only N, Z and C (C = 1 when pair >= word), and asserts neither destination strobe.
- R6: Operation codes 3 (increment) and 4 (decrement) give word + 1 or word - 1 modulo 2^16, with the carry or borrow crossing from the low byte to the high byte. They assert mem_we_o only and enable only N and Z.
- R7: Operation code 5 (load) passes the word unchanged to the result, asserts pair_we_o only and enables only N and Z.
- R8: For every defined operation, N equals result bit 15 and Z is 1 exactly when all sixteen result bits are zero.
- R9: The low result byte (bits 7:0) appears on res_lo_o for the low register and the high byte (bits 15:8) appears on res_hi_o for the high register. The pair and word inputs use the same split.
- R10: Operation codes 6 and 7 enable no flag and assert no destination strobe. Every flag output is 0 whenever its write-enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation select (0 add, 1 subtract, 2 compare, 3 increment, 4 decrement, 5 load) |
| pair_lo_i | input | BYTE_W | Low register of the pair |
| pair_hi_i | input | BYTE_W | High register of the pair |
| word_lo_i | input | BYTE_W | Low byte of the memory word |
| word_hi_i | input | BYTE_W | High byte of the memory word |
| res_lo_o | output | BYTE_W | Result bits 7:0 |
| res_hi_o | output | BYTE_W | Result bits 15:8 |
| flag_n_o | output | 1 | Negative flag value |
| flag_v_o | output | 1 | Overflow flag value |
| flag_h_o | output | 1 | Half-carry flag value |
| flag_z_o | output | 1 | Zero flag value |
| flag_c_o | output | 1 | Carry flag value |
| we_n_o | output | 1 | Negative flag write-enable |
| we_v_o | output | 1 | Overflow flag write-enable |
| we_h_o | output | 1 | Half-carry flag write-enable |
| we_z_o | output | 1 | Zero flag write-enable |
| we_c_o | output | 1 | Carry flag write-enable |
| pair_we_o | output | 1 | Result is written to the register pair |
| mem_we_o | output | 1 | Result is written back to the memory word |

## Verification
The bench builds the unit with its default byte width of 8, so the word is sixteen bits wide. Every carry boundary the flags depend on then falls at its intended place: the byte seam at bit 8, the half-carry at bit 12 and the sign at bit 15. With these widths, a few hundred random pair and word draws often cross all three boundaries, and directed operands pin the extremes: 0xFFFF+1, 0x7FFF+1, 0x0000-1, 0x8000-1, equal operands, 0x00FF increment and 0x0100 decrement. With the default width, the unused operation codes are also directly reachable.

// File: rtl/ya_alu_pkg.sv
package ya_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_CMP  = 3'd2,
    OP_INC  = 3'd3,
    OP_DEC  = 3'd4,
    OP_LOAD = 3'd5
  } op_e;

  // second-operand selection for the shared adder
  typedef enum logic [1:0] {
    B_WORD  = 2'd0,
    B_NWORD = 2'd1,
    B_ZERO  = 2'd2,
    B_ONES  = 2'd3
  } bsel_e;

  typedef struct packed {
    logic  a_from_word;  // adder A input: word instead of pair
    bsel_e bsel;
    logic  cin;
    logic  bypass;       // result is the word itself
    logic  pair_we;
    logic  mem_we;
    logic  en_n;
    logic  en_v;
    logic  en_h;
    logic  en_z;
    logic  en_c;
  } ctl_t;

endpackage

// File: rtl/ya_alu_dec.sv
module ya_alu_dec
  import ya_alu_pkg::*;
(
  input  logic [2:0] op_i,
  output ctl_t       ctl_o
);

  always_comb begin
    ctl_o      = '0;
    ctl_o.bsel = B_WORD;
    case (op_i)
      OP_ADD: begin
        ctl_o.pair_we = 1'b1;
        {ctl_o.en_n, ctl_o.en_v, ctl_o.en_h, ctl_o.en_z, ctl_o.en_c} = 5'b11111;
      end
      OP_SUB: begin
        ctl_o.bsel    = B_NWORD;
        ctl_o.cin     = 1'b1;
        ctl_o.pair_we = 1'b1;
        {ctl_o.en_n, ctl_o.en_v, ctl_o.en_h, ctl_o.en_z, ctl_o.en_c} = 5'b11111;
      end
      OP_CMP: begin
        ctl_o.bsel = B_NWORD;
        ctl_o.cin  = 1'b1;
        {ctl_o.en_n, ctl_o.en_z, ctl_o.en_c} = 3'b111;
      end
      OP_INC: begin
        ctl_o.a_from_word = 1'b1;
        ctl_o.bsel        = B_ZERO;
        ctl_o.cin         = 1'b1;
        ctl_o.mem_we      = 1'b1;
        {ctl_o.en_n, ctl_o.en_z} = 2'b11;
      end
      OP_DEC: begin
        ctl_o.a_from_word = 1'b1;
        ctl_o.bsel        = B_ONES;
        ctl_o.mem_we      = 1'b1;
        {ctl_o.en_n, ctl_o.en_z} = 2'b11;
      end
      OP_LOAD: begin
        ctl_o.bypass  = 1'b1;
        ctl_o.pair_we = 1'b1;
        {ctl_o.en_n, ctl_o.en_z} = 2'b11;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ya_alu_adder.sv
module ya_alu_adder #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2
) (
  input  logic [BYTE_W*NBYTES-1:0] a_i,
  input  logic [BYTE_W*NBYTES-1:0] b_i,
  input  logic                     cin_i,
  output logic [BYTE_W*NBYTES-1:0] sum_o,
  output logic                     cout_o,
  output logic                     half_o,
  output logic                     ovf_o
);

  localparam int W        = BYTE_W * NBYTES;
  localparam int HALF_BIT = W - 4;

  logic [NBYTES:0] carry;
  logic            msb_cin;

  assign carry[0] = cin_i;

  for (genvar g = 0; g < NBYTES; g++) begin : g_slice
    logic [BYTE_W:0] part;
    assign part = {1'b0, a_i[g*BYTE_W +: BYTE_W]}
                + {1'b0, b_i[g*BYTE_W +: BYTE_W]}
                + {{BYTE_W{1'b0}}, carry[g]};
    assign sum_o[g*BYTE_W +: BYTE_W] = part[BYTE_W-1:0];
    assign carry[g+1]                = part[BYTE_W];
  end

  assign cout_o  = carry[NBYTES];
  assign msb_cin = a_i[W-1] ^ b_i[W-1] ^ sum_o[W-1];
  assign half_o  = a_i[HALF_BIT] ^ b_i[HALF_BIT] ^ sum_o[HALF_BIT];
  assign ovf_o   = cout_o ^ msb_cin;

  // R4: overflow only when both operands share a sign and the sum differs
  always_comb begin
    if (ovf_o)
      p_ovf_sign_r4: assert (a_i[W-1] == b_i[W-1] && sum_o[W-1] != a_i[W-1]);
  end

endmodule

// File: rtl/ya_alu_flags.sv
module ya_alu_flags #(
  parameter int W = 16
) (
  input  logic [W-1:0] res_i,
  output logic         neg_o,
  output logic         zero_o
);

  assign neg_o  = res_i[W-1];
  assign zero_o = ~|res_i;

endmodule

// File: rtl/ya_word_alu.sv
module ya_word_alu
  import ya_alu_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [2:0]        op_i,
  input  logic [BYTE_W-1:0] pair_lo_i,
  input  logic [BYTE_W-1:0] pair_hi_i,
  input  logic [BYTE_W-1:0] word_lo_i,
  input  logic [BYTE_W-1:0] word_hi_i,
  output logic [BYTE_W-1:0] res_lo_o,
  output logic [BYTE_W-1:0] res_hi_o,
  output logic              flag_n_o,
  output logic              flag_v_o,
  output logic              flag_h_o,
  output logic              flag_z_o,
  output logic              flag_c_o,
  output logic              we_n_o,
  output logic              we_v_o,
  output logic              we_h_o,
  output logic              we_z_o,
  output logic              we_c_o,
  output logic              pair_we_o,
  output logic              mem_we_o
);

  localparam int NBYTES = 2;
  localparam int W      = BYTE_W * NBYTES;

  ctl_t         ctl;
  logic [W-1:0] pair_w;
  logic [W-1:0] word_w;
  logic [W-1:0] op_a;
  logic [W-1:0] op_b;
  logic [W-1:0] sum;
  logic [W-1:0] result;
  logic         cout;
  logic         half;
  logic         ovf;
  logic         neg_raw;
  logic         zero_raw;

  assign pair_w = {pair_hi_i, pair_lo_i};
  assign word_w = {word_hi_i, word_lo_i};

  ya_alu_dec u_dec (
    .op_i  (op_i),
    .ctl_o (ctl)
  );

  assign op_a = ctl.a_from_word ? word_w : pair_w;

  always_comb begin
    case (ctl.bsel)
      B_WORD:  op_b = word_w;
      B_NWORD: op_b = ~word_w;
      B_ZERO:  op_b = '0;
      default: op_b = '1;
    endcase
  end

  ya_alu_adder #(
    .BYTE_W (BYTE_W),
    .NBYTES (NBYTES)
  ) u_add (
    .a_i    (op_a),
    .b_i    (op_b),
    .cin_i  (ctl.cin),
    .sum_o  (sum),
    .cout_o (cout),
    .half_o (half),
    .ovf_o  (ovf)
  );

  assign result = ctl.bypass ? word_w : sum;

  ya_alu_flags #(.W(W)) u_flags (
    .res_i  (result),
    .neg_o  (neg_raw),
    .zero_o (zero_raw)
  );

  assign res_lo_o  = result[BYTE_W-1:0];
  assign res_hi_o  = result[W-1:BYTE_W];

  assign we_n_o    = ctl.en_n;
  assign we_v_o    = ctl.en_v;
  assign we_h_o    = ctl.en_h;
  assign we_z_o    = ctl.en_z;
  assign we_c_o    = ctl.en_c;
  assign flag_n_o  = ctl.en_n & neg_raw;
  assign flag_v_o  = ctl.en_v & ovf;
  assign flag_h_o  = ctl.en_h & half;
  assign flag_z_o  = ctl.en_z & zero_raw;
  assign flag_c_o  = ctl.en_c & cout;
  assign pair_we_o = ctl.pair_we;
  assign mem_we_o  = ctl.mem_we;

  always_comb begin
    // R1: one destination at most
    p_one_dest_r1: assert (!(pair_we_o && mem_we_o));
    // R8: a value cannot be both negative and zero
    p_nz_excl_r8: assert (!(flag_n_o && flag_z_o));
    if (op_i == OP_CMP) begin
      // R5: compare leaves both destinations and V/H untouched
      p_cmp_quiet_r5: assert (!pair_we_o && !mem_we_o && !we_v_o && !we_h_o);
      p_cmp_carry_r5: assert (flag_c_o == (pair_w >= word_w));
    end
    if (op_i == OP_SUB)
      p_sub_noborrow_r4: assert (flag_c_o == (pair_w >= word_w));
    if (op_i == OP_INC && result == '0)
      p_inc_wrap_r6: assert (word_w == '1);
    if (op_i == 3'd6 || op_i == 3'd7)
      p_idle_r10: assert (!pair_we_o && !mem_we_o && !we_n_o && !we_z_o && !we_c_o);
  end

endmodule

// File: tb/ya_word_alu_test.sv
module ya_word_alu_test;

  logic       clk;
  logic       rst_n;
  logic [2:0] op;
  logic [7:0] p_lo, p_hi, w_lo, w_hi;
  logic [7:0] r_lo, r_hi;
  logic       fn, fv, fh, fz, fc;
  logic       en_n, en_v, en_h, en_z, en_c;
  logic       pwe, mwe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  ya_word_alu #(.BYTE_W(8)) uut (
    .op_i(op), .pair_lo_i(p_lo), .pair_hi_i(p_hi),
    .word_lo_i(w_lo), .word_hi_i(w_hi),
    .res_lo_o(r_lo), .res_hi_o(r_hi),
    .flag_n_o(fn), .flag_v_o(fv), .flag_h_o(fh), .flag_z_o(fz), .flag_c_o(fc),
    .we_n_o(en_n), .we_v_o(en_v), .we_h_o(en_h), .we_z_o(en_z), .we_c_o(en_c),
    .pair_we_o(pwe), .mem_we_o(mwe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [15:0] res;
    logic n, v, h, z, c;
    logic en_n, en_v, en_h, en_z, en_c;
    logic pw, mw;
  } exp_t;

  function automatic int sgn(int x);
    return (x >= 32768) ? x - 65536 : x;
  endfunction

  function automatic exp_t model(int o, int p, int w);
    exp_t e;
    int   s;
    e = '0;
    case (o)
      0: begin // R1
        e.res = 16'((p + w) & 'hFFFF);
        e.c   = (p + w) > 'hFFFF;
        e.h   = ((p & 'hFFF) + (w & 'hFFF)) >= 'h1000;
        s     = sgn(p) + sgn(w);
        e.v   = (s > 32767) || (s < -32768);
        e.pw  = 1'b1;
        {e.en_n, e.en_v, e.en_h, e.en_z, e.en_c} = 5'b11111;
      end
      1: begin // R2
        e.res = 16'((p - w) & 'hFFFF);
        e.c   = p >= w;
        e.h   = (p & 'hFFF) >= (w & 'hFFF);
        s     = sgn(p) - sgn(w);
        e.v   = (s > 32767) || (s < -32768);
        e.pw  = 1'b1;
        {e.en_n, e.en_v, e.en_h, e.en_z, e.en_c} = 5'b11111;
      end
      2: begin // R5
        e.res = 16'((p - w) & 'hFFFF);
        e.c   = p >= w;
        {e.en_n, e.en_z, e.en_c} = 3'b111;
      end
      3, 4: begin // R6
        e.res = 16'(((o == 3) ? w + 1 : w - 1) & 'hFFFF);
        e.mw  = 1'b1;
        {e.en_n, e.en_z} = 2'b11;
      end
      5: begin // R7
        e.res = 16'(w);
        e.pw  = 1'b1;
        {e.en_n, e.en_z} = 2'b11;
      end
      default: ;
    endcase
    if (o <= 5) begin
      e.n = e.res[15];
      e.z = (e.res == 16'h0);
    end
    return e;
  endfunction

  function automatic string optag(int o);
    case (o)
      0: return "R1";
      1: return "R2";
      2: return "R5";
      3, 4: return "R6";
      5: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s op=%0d p=%04h w=%04h actual=%0h expected=%0h",
               tag, op, {p_hi, p_lo}, {w_hi, w_lo}, act, expv);
    end
  endtask

  task automatic apply(int o, int p, int w);
    exp_t e;
    string t;
    @(negedge clk);
    op   = 3'(o);
    p_lo = 8'(p); p_hi = 8'(p >> 8);
    w_lo = 8'(w); w_hi = 8'(w >> 8);
    #2;
    e = model(o, p, w);
    t = optag(o);
    if (o <= 5) begin
      chk({t, " result"}, {r_hi, r_lo}, e.res);
      chk("R9 low byte", r_lo, e.res[7:0]);
      chk("R9 high byte", r_hi, e.res[15:8]);
    end
    chk({t, " pair_we"}, pwe, e.pw);
    chk({t, " mem_we"}, mwe, e.mw);
    chk({t, " enables"}, {en_n, en_v, en_h, en_z, en_c},
        {e.en_n, e.en_v, e.en_h, e.en_z, e.en_c});
    chk("R8 N", fn, e.n);
    chk("R8 Z", fz, e.z);
    chk("R3 H", fh, e.h);
    chk("R4 V", fv, e.v);
    chk((o == 2) ? "R5 C" : "R4 C", fc, e.c);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    op = 3'd0; p_lo = 0; p_hi = 0; w_lo = 0; w_hi = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset-state inputs: add of zeros gives Z only
    @(negedge clk);
    chk("R1 reset result", {r_hi, r_lo}, 0);
    chk("R8 reset Z", fz, 1);

    // directed corners
    apply(0, 'hFFFF, 'h0001);  // R1 wrap, C and Z
    apply(0, 'h0FFF, 'h0001);  // R3 half-carry
    apply(0, 'h7FFF, 'h0001);  // R4 overflow
    apply(0, 'h00FF, 'h0001);  // byte seam
    apply(1, 'h0000, 'h0001);  // R2 borrow
    apply(1, 'h8000, 'h0001);  // R4 overflow on subtract
    apply(1, 'h1234, 'h1234);  // R2 equal, C=1 Z=1
    apply(1, 'h1000, 'h0001);  // R3 half borrow
    apply(1, 'h0000, 'h8000);  // R4 negate minimum
    apply(2, 'h4000, 'h4000);  // R5 equal
    apply(2, 'h0001, 'h0002);  // R5 less
    apply(3, 0, 'h00FF);       // R6 carry across byte
    apply(3, 0, 'hFFFF);       // R6 wrap to zero
    apply(4, 0, 'h0100);       // R6 borrow across byte
    apply(4, 0, 'h0000);       // R6 wrap to all ones
    apply(5, 'h1111, 'h8000);  // R7 negative load
    apply(5, 'hFFFF, 'h0000);  // R7 zero load
    apply(6, 'h1234, 'h5678);  // R10
    apply(7, 'hFFFF, 'hFFFF);  // R10

    seed = $urandom(32'd20240611);
    for (int i = 0; i < 600; i++) begin
      apply(int'($urandom_range(0, 7)), int'($urandom_range(0, 65535)),
            int'($urandom_range(0, 65535)));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule